// File: doc/BRIEF.md
# Three-Wire Motion Sensor Serial Master

This block talks to an optical motion sensor over a half-duplex serial link with three wires: a clock it drives, one data line that both sides share, and an active-low select. The host issues one command at a time: read one register, write one register, fetch a two-byte motion report, or send a bare select pulse that resynchronises the sensor's serial port. Each command carries an address and a write byte. The block returns up to two received bytes and pulses a done strobe when the select line goes high again.

All timing comes from the system clock. The clock-low and clock-high phase lengths, the wait after every byte sent, the hold after the last byte received, and the width of the resync pulse are all parameters. The data line is turned around mid-frame: the block drives it, together with an output enable, only while it sends. It releases the line before the sensor's first bit appears. The sensor model used for checking exists only in the testbench.

Top module: `tws_master`

## Requirements
- R1: After reset, and whenever no command is in progress, `cs_n`=1, `sclk`=1, `sdio_oe`=0, `busy`=0 and `done`=0.
- R2: A bit cell holds `sclk` low for HALF_CYC cycles and then high for HALF_CYC cycles. A bit being sent is placed on `sdio_o` from the start of the low phase. Bytes are sent and received most significant bit first.
- R3: A write (`cmd_op`=1) keeps `cs_n` low across two bytes. The first is `cmd_addr` with bit 7 forced to 1; the second is `cmd_wdata`. Each sent byte is followed by TURN_CYC cycles with `sclk` high and `sdio_oe` low. After the second of these waits, `cs_n` returns high.
- R4: A read (`cmd_op`=0) sends `cmd_addr` with bit 7 forced to 0, waits TURN_CYC cycles, and then clocks in one byte. Each bit is sampled in the last cycle of its low phase. The byte appears on `rx_first`.
- R5: A burst (`cmd_op`=2) sends address 0x63 and clocks in two bytes. The first goes to `rx_first` and the second to `rx_second`, both as signed two's-complement values. Select is then released without clocking further bytes.
- R6: After the last received bit, `cs_n` stays low with `sclk` high for HOLD_CYC cycles before it is released.
- R7: A sync (`cmd_op`=3) drives `cs_n` low for SYNC_CYC cycles. During that time `sclk` stays high and `sdio_oe` stays low.
- R8: `sdio_oe` is high only during the bit cells of a sent byte. It is low in every wait, during every received bit, and whenever `cs_n` is high.
- R9: A command is taken when `cmd_valid`=1 and `busy`=0. `busy` and `cs_n`=0 begin in the next cycle. `done` is a one-cycle pulse in the cycle `cs_n` returns high, and `busy` falls in that same cycle. `cmd_valid` has no effect while `busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 read, 1 write, 2 burst, 3 sync |
| cmd_addr | input | 8 | Register address (bit 7 replaced by the block) |
| cmd_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_first | output | 8 | Read byte, or first burst byte (signed) |
| rx_second | output | 8 | Second burst byte (signed) |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low select |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line input |

## Verification
The hardest situation to reach is the handover of the shared line: the cycle where the block has just released `sdio_oe` and the sensor begins driving. A fault there looks identical to a correct frame at the data outputs. The bench's sensor model changes its data only on falling clock edges in read phase and checks the enable on every rising edge. A per-cycle reference trace, built from the phase lengths, compares select, clock, enable, busy and done on every clock across reads, writes and bursts. Host requests are also injected mid-frame while the block is busy, which shows that they leave the trace untouched.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_BURST = 2'd2,
    OP_SYNC  = 2'd3
  } tws_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_LOW,
    ST_HIGH,
    ST_TURN,
    ST_HOLD
  } tws_state_e;
endpackage

// File: rtl/tws_rst_sync.sv
module tws_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tws_timer.sv
module tws_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/tws_shreg.sv
module tws_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic [W-1:0] value,
  output logic         msb
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_val;
    else if (shift) sh_d = {sh_q[W-2:0], in_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign value = sh_q;
  assign msb   = sh_q[W-1];
endmodule

// File: rtl/tws_master.sv
module tws_master
  import tws_pkg::*;
#(
  parameter int         HALF_CYC   = 4,
  parameter int         TURN_CYC   = 12,
  parameter int         HOLD_CYC   = 6,
  parameter int         SYNC_CYC   = 100,
  parameter logic [7:0] BURST_ADDR = 8'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic signed [7:0] rx_first,
  output logic signed [7:0] rx_second,
  output logic              sclk,
  output logic              cs_n,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic              sdio_i
);
  localparam int MAX_A  = (HALF_CYC > TURN_CYC) ? HALF_CYC : TURN_CYC;
  localparam int MAX_B  = (HOLD_CYC > SYNC_CYC) ? HOLD_CYC : SYNC_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SYNC_LD = CNT_W'(SYNC_CYC - 1);

  logic       rst_i_n;
  tws_state_e state_q, state_d;
  tws_op_e    op_q, op_d;
  logic [7:0] wdata_q, wdata_d;
  logic [2:0] bit_q, bit_d;
  logic [1:0] byte_q, byte_d;
  logic       done_q, done_d;
  logic [7:0] rx0_q, rx0_d, rx1_q, rx1_d;

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_msb;
  logic [7:0]       sh_val, sh_value;
  logic             wr_byte, last_byte;

  tws_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tws_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  tws_shreg #(.W(8)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (sh_shift),
    .in_bit   (sdio_i),
    .value    (sh_value),
    .msb      (sh_msb)
  );

  // byte 0 is always the address; byte 1 is sent only on a write
  assign wr_byte   = (byte_q == 2'd0) || (byte_q == 2'd1 && op_q == OP_WRITE);
  assign last_byte = (op_q == OP_BURST) ? (byte_q == 2'd2) : (byte_q == 2'd1);

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    wdata_d  = wdata_q;
    bit_d    = bit_q;
    byte_d   = byte_q;
    done_d   = 1'b0;
    rx0_d    = rx0_q;
    rx1_d    = rx1_q;
    tmr_load = 1'b0;
    tmr_val  = HALF_LD;
    sh_load  = 1'b0;
    sh_val   = wdata_q;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          op_d     = tws_op_e'(cmd_op);
          wdata_d  = cmd_wdata;
          bit_d    = 3'd0;
          byte_d   = 2'd0;
          tmr_load = 1'b1;
          if (tws_op_e'(cmd_op) == OP_SYNC) begin
            tmr_val = SYNC_LD;
            state_d = ST_SYNC;
          end else begin
            tmr_val = HALF_LD;
            sh_load = 1'b1;
            unique case (tws_op_e'(cmd_op))
              OP_WRITE: sh_val = {1'b1, cmd_addr[6:0]};
              OP_BURST: sh_val = BURST_ADDR;
              default:  sh_val = {1'b0, cmd_addr[6:0]};
            endcase
            state_d = ST_LOW;
          end
        end
      end
      ST_SYNC: begin
        if (tmr_zero) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          sh_shift = !wr_byte;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
          state_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          sh_shift = wr_byte;
          tmr_load = 1'b1;
          if (bit_q != 3'd7) begin
            bit_d   = bit_q + 3'd1;
            tmr_val = HALF_LD;
            state_d = ST_LOW;
          end else if (wr_byte) begin
            tmr_val = TURN_LD;
            state_d = ST_TURN;
          end else begin
            if (byte_q == 2'd2) rx1_d = sh_value;
            else                rx0_d = sh_value;
            if (last_byte) begin
              tmr_val = HOLD_LD;
              state_d = ST_HOLD;
            end else begin
              bit_d   = 3'd0;
              byte_d  = byte_q + 2'd1;
              tmr_val = HALF_LD;
              state_d = ST_LOW;
            end
          end
        end
      end
      ST_TURN: begin
        if (tmr_zero) begin
          if (last_byte) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            bit_d    = 3'd0;
            byte_d   = byte_q + 2'd1;
            sh_load  = 1'b1;
            sh_val   = wdata_q;
            tmr_load = 1'b1;
            tmr_val  = HALF_LD;
            state_d  = ST_LOW;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
      wdata_q <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      done_q  <= 1'b0;
      rx0_q   <= '0;
      rx1_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      wdata_q <= wdata_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      done_q  <= done_d;
      rx0_q   <= rx0_d;
      rx1_q   <= rx1_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign cs_n      = (state_q == ST_IDLE);
  assign sclk      = (state_q != ST_LOW);
  assign sdio_oe   = (state_q == ST_LOW || state_q == ST_HIGH) && wr_byte;
  assign sdio_o    = sdio_oe & sh_msb;
  assign done      = done_q;
  assign rx_first  = rx0_q;
  assign rx_second = rx1_q;

  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    cs_n |-> sclk);
  a_r2_low_phase: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(sclk) |=> !sclk);
  a_r7_sync_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_SYNC) |-> (sclk && !sdio_oe));
  a_r8_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_i_n)
    sdio_oe |-> !cs_n);
  a_r8_released_before_read: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_TURN && tmr_zero && !last_byte && op_q != OP_WRITE)
      |=> (!sdio_oe && !sclk));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  a_r9_done_with_cs: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(cs_n) |-> done);
endmodule

// File: tb/tb_tws_master.sv
module tb_tws_master;
  localparam int HALF = 4;
  localparam int TURN = 12;
  localparam int HOLD = 6;
  localparam int SYNC = 100;

  logic clk, rst_n, cmd_valid, sdio_i;
  logic [1:0] cmd_op;
  logic [7:0] cmd_addr, cmd_wdata;
  logic busy, done, sclk, cs_n, sdio_o, sdio_oe;
  logic signed [7:0] rx_first, rx_second;

  int n_chk = 0, n_fail = 0, cyc = 0;

  tws_master #(.HALF_CYC(HALF), .TURN_CYC(TURN), .HOLD_CYC(HOLD),
               .SYNC_CYC(SYNC), .BURST_ADDR(8'h63)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rx_first(rx_first), .rx_second(rx_second), .sclk(sclk), .cs_n(cs_n),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string tagname(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference trace: {cs_n, sclk, oe, done, busy} per cycle after acceptance
  logic [4:0] exp_q[$];
  int         tag_q[$];

  task automatic push(input int tag, input logic [4:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic add_byte(input bit wr);
    for (int b = 0; b < 8; b++) begin
      push(wr ? 2 : 4, {1'b0, 1'b0, wr, 1'b0, 1'b1}, HALF);
      push(wr ? 2 : 4, {1'b0, 1'b1, wr, 1'b0, 1'b1}, HALF);
    end
    if (wr) push(3, 5'b01001, TURN);
  endtask

  always @(negedge clk) begin
    logic [4:0] e;
    int t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = 5'b11000;
      t = 1;
    end
    chk({cs_n, sclk, sdio_oe, done, busy} === e, tagname(t),
        int'({cs_n, sclk, sdio_oe, done, busy}), int'(e));
  end

  // behavioural sensor model
  logic [7:0] sregs [0:127];
  logic [7:0] got_q[$];
  logic [7:0] send_q[$];
  logic [7:0] burst_x, burst_y, sh, cur;
  logic [6:0] waddr;
  int nbits, rbit, phase;
  logic prev_sclk = 1'b1, prev_cs = 1'b1;

  always @(sclk or cs_n) begin
    if (prev_cs === 1'b1 && cs_n === 1'b0) begin
      phase = 0; nbits = 0; rbit = 0;
    end
    if (cs_n === 1'b0 && prev_sclk === 1'b0 && sclk === 1'b1 && phase < 2) begin
      chk(sdio_oe === 1'b1, "R8", int'(sdio_oe), 1);
      sh = {sh[6:0], sdio_o};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        got_q.push_back(sh);
        if (phase == 0) begin
          if (sh[7]) begin
            waddr = sh[6:0];
            phase = 1;
          end else begin
            if (sh == 8'h63) begin
              send_q.push_back(burst_x);
              send_q.push_back(burst_y);
            end else begin
              send_q.push_back(sregs[sh[6:0]]);
            end
            phase = 2;
          end
        end else begin
          sregs[waddr] = sh;
          phase = 3;
        end
      end
    end
    if (cs_n === 1'b0 && prev_sclk === 1'b1 && sclk === 1'b0 && phase == 2) begin
      if (rbit == 0) cur = (send_q.size() > 0) ? send_q.pop_front() : 8'h00;
      sdio_i = cur[7];
      cur = {cur[6:0], 1'b0};
      rbit = (rbit + 1) % 8;
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    got_q.delete();
    send_q.delete();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(posedge clk);
    case (op)
      2'd3: push(7, 5'b01001, SYNC);
      2'd1: begin add_byte(1'b1); add_byte(1'b1); end
      2'd0: begin add_byte(1'b1); add_byte(1'b0); push(6, 5'b01001, HOLD); end
      default: begin
        add_byte(1'b1); add_byte(1'b0); add_byte(1'b0); push(6, 5'b01001, HOLD);
      end
    endcase
    push(9, 5'b11010, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done;
    do @(negedge clk); while (done !== 1'b1);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R9", cyc, 0);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) sregs[i] = 8'(i) ^ 8'h5A;
    sregs[0] = 8'h12;
    burst_x = 8'h00; burst_y = 8'h00;
    sh = '0; cur = '0; waddr = '0; nbits = 0; rbit = 0; phase = 3;
    sdio_i = 1'b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = '0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    chk(rx_first === 8'sd0 && rx_second === 8'sd0, "R1", int'(rx_first), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 write, with a host request injected while busy (R9)
    issue(2'd1, 8'h19, 8'h9A);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    chk(got_q.size() == 2, "R3", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk(got_q[0] == 8'h99, "R3", got_q[0], 8'h99);
      chk(got_q[1] == 8'h9A, "R2", got_q[1], 8'h9A);
    end
    chk(sregs[8'h19] == 8'h9A, "R3", sregs[8'h19], 8'h9A);
    repeat (3) @(negedge clk);

    // R4 read back
    issue(2'd0, 8'h19, 8'h00);
    wait_done();
    chk(rx_first == 8'sh9A - 8'sd0, "R4", rx_first, 8'h9A);
    chk(got_q.size() == 1 && got_q[0] == 8'h19, "R4", got_q[0], 8'h19);
    repeat (2) @(negedge clk);

    // R4 read with bit 7 set by host: must go out cleared
    issue(2'd0, 8'h80, 8'h00);
    wait_done();
    chk(got_q.size() == 1 && got_q[0] == 8'h00, "R4", got_q[0], 8'h00);
    chk(rx_first == 8'sh12, "R4", rx_first, 8'h12);

    // R5 bursts, signed results
    burst_x = 8'h85; burst_y = 8'h07;
    issue(2'd2, 8'h00, 8'h00);
    wait_done();
    chk(got_q.size() == 1 && got_q[0] == 8'h63, "R5", got_q[0], 8'h63);
    chk(int'(rx_first) == -123, "R5", int'(rx_first), -123);
    chk(int'(rx_second) == 7, "R5", int'(rx_second), 7);
    burst_x = 8'h7F; burst_y = 8'h80;
    issue(2'd2, 8'h45, 8'h11);
    wait_done();
    chk(int'(rx_first) == 127, "R5", int'(rx_first), 127);
    chk(int'(rx_second) == -128, "R5", int'(rx_second), -128);

    // R7 sync: no bytes clocked
    issue(2'd3, 8'hFF, 8'hFF);
    wait_done();
    chk(got_q.size() == 0, "R7", got_q.size(), 0);

    // boundary patterns: top address, all-zero and all-one data
    issue(2'd1, 8'h7F, 8'h00);
    wait_done();
    chk(got_q.size() == 2 && got_q[0] == 8'hFF, "R3", got_q[0], 8'hFF);
    issue(2'd0, 8'h7F, 8'h00);
    wait_done();
    chk(rx_first == 8'sd0, "R4", rx_first, 0);
    issue(2'd1, 8'h00, 8'hFF);
    wait_done();
    issue(2'd0, 8'h00, 8'h00);
    wait_done();
    chk(rx_first == -8'sd1, "R4", rx_first, 8'hFF);
    chk(int'(rx_second) == -128, "R6", int'(rx_second), -128);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule